// File: doc/BRIEF.md
# Supply Voltage Monitor Qualifier and Event Controller

This block sits behind an analog comparator that reports whether a monitored supply is above or below a programmed threshold. The comparator bit arrives asynchronously. The block synchronizes it and can pass it through a digital noise filter. It then turns a valid threshold crossing into one of two events: a maskable interrupt pulse or a held reset request. The whole block runs on the low-speed oscillator clock. The filter samples on every 1st, 2nd, 4th or 8th oscillator cycle.

Software programs the block through a set of static control inputs:
- a threshold code, which is forwarded to the reference ladder;
- the filter divider and a filter bypass;
- the choice between interrupt and reset;
- the interrupt edge;
- the reset release style;
- three enables: comparator gate, event enable and circuit enable.

A sticky detection flag records each qualifying event until software clears it.

The comparator bit reads 1 when the supply is above the threshold and 0 when it is below. A fall is a 1-to-0 change and a rise is a 0-to-1 change.

Top module: `volt_mon_ctrl`

## Requirements
- R1: After reset, `irq_o`, `rst_req_o`, `det_o` and `ladder_sel_o` are all 0.
- R2: `ladder_sel_o` equals the `lvl_code_i` value registered one cycle earlier.
- R3: In interrupt mode (`mode_rst_i`=0) with the filter bypassed, every qualifying change of the comparator gives one single-cycle `irq_o` pulse. The `irq_edge_i` codes are 00 = fall, 01 = rise, 10 = both, 11 = fall.
- R4: With the filter enabled, the qualified level follows the comparator only after two consecutive samples agree. Samples are taken every n = 2^`div_sel_i` cycles. A low pulse shorter than n cycles raises no event, while a sustained fall raises one.
- R5: When the filter is switched from bypass to enabled, no event is raised for 2n+3 oscillator cycles. A crossing that settles inside that window is absorbed without an event.
- R6: With `cmp_en_i`=0 the comparator is treated as above the threshold, so a real fall raises no event.
- R7: No interrupt or reset request is produced unless both `evt_en_i` and `mon_en_i` are 1.
- R8: `det_o` is set on every qualifying event and is cleared by a one-cycle `det_clr_i` pulse.
- R9: In reset mode (`mode_rst_i`=1) a fall asserts `rst_req_o`, and `irq_o` stays 0.
- R10: With `neg_type_i`=1, `rst_req_o` stays high for exactly 256 cycles from its assertion, whatever the comparator does.
- R11: With `neg_type_i`=0, `rst_req_o` stays high while the supply is low. It is released after 256 consecutive cycles above the threshold, and any dip restarts that count.
- R12: In interrupt mode `rst_req_o` never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Asynchronous comparator result, 1 = above threshold |
| lvl_code_i | input | 4 | Threshold code for the reference ladder |
| div_sel_i | input | 2 | Filter sample divider, n = 2^value |
| filt_dis_i | input | 1 | 1 bypasses the filter |
| mode_rst_i | input | 1 | 0 = interrupt action, 1 = reset action |
| neg_type_i | input | 1 | Reset release style |
| irq_edge_i | input | 2 | Interrupt edge select |
| cmp_en_i | input | 1 | Gates the comparator result into the block |
| evt_en_i | input | 1 | Interrupt/reset enable |
| mon_en_i | input | 1 | Circuit enable |
| det_clr_i | input | 1 | Pulse that clears the detection flag |
| ladder_sel_o | output | 4 | Registered threshold code |
| irq_o | output | 1 | Single-cycle interrupt request |
| rst_req_o | output | 1 | Held reset request |
| det_o | output | 1 | Sticky detection flag |

## Verification
The hardest case to reach is a crossing that completes inside the settling window after the filter is enabled. The filter must take the new level in that window without raising an event. The stimulus enables the filter and drops the comparator on the same cycle, with a divider that makes the worst-case filter delay fall one cycle short of the window's end. A later drop outside the window confirms that events are still raised there. For reset release style 0, the bench inserts a short dip during recovery and checks that the release time is measured from the final rise.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int unsigned DIV_SEL_W  = 2;
  localparam int unsigned DIV_MAX    = 1 << ((1 << DIV_SEL_W) - 1);
  localparam int unsigned SETTLE_MAX = 2 * DIV_MAX + 3;
  localparam int unsigned SETTLE_W   = $clog2(SETTLE_MAX + 1);
  localparam int unsigned DIV_CNT_W  = $clog2(DIV_MAX);

  typedef enum logic [1:0] {
    EDGE_FALL  = 2'b00,
    EDGE_RISE  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_RSVD  = 2'b11
  } irq_edge_e;
endpackage

// File: rtl/vm_sync.sv
module vm_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/vm_filter.sv
module vm_filter
  import vm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmp_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 filt_dis_i,
  output logic                 lvl_o,
  output logic                 settled_o
);
  logic [DIV_CNT_W-1:0] div_cnt_q, div_last;
  logic                 samp_en;
  logic                 samp_q, filt_q;
  logic [SETTLE_W-1:0]  settle_q, settle_load;

  assign div_last    = DIV_CNT_W'((1 << div_sel_i) - 1);
  assign samp_en     = (div_cnt_q == div_last);
  assign settle_load = SETTLE_W'((2 << div_sel_i) + 3);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      div_cnt_q <= '0;
    else if (samp_en) div_cnt_q <= '0;
    else              div_cnt_q <= div_cnt_q + 1'b1;

  // two agreeing samples move the output; bypass keeps state tracking
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      samp_q <= 1'b1;
      filt_q <= 1'b1;
    end else if (filt_dis_i) begin
      samp_q <= cmp_i;
      filt_q <= cmp_i;
    end else if (samp_en) begin
      samp_q <= cmp_i;
      if (cmp_i == samp_q) filt_q <= cmp_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              settle_q <= SETTLE_W'(SETTLE_MAX);
    else if (filt_dis_i)      settle_q <= settle_load;
    else if (settle_q != '0)  settle_q <= settle_q - 1'b1;

  assign lvl_o     = filt_dis_i ? cmp_i : filt_q;
  assign settled_o = filt_dis_i | (settle_q == '0);

  p_filt_on_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(filt_q) && $past(!filt_dis_i)) |-> $past(samp_en));
endmodule

// File: rtl/vm_event.sv
module vm_event
  import vm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  logic      settled_i,
  input  logic      evt_en_i,
  input  logic      mon_en_i,
  input  logic      mode_rst_i,
  input  irq_edge_e irq_edge_i,
  input  logic      det_clr_i,
  input  logic      rst_busy_i,
  output logic      irq_o,
  output logic      fire_o,
  output logic      det_o
);
  logic prev_q, irq_q, det_q;
  logic fall, rise, hit, active, irq_set;

  assign fall   = prev_q & ~lvl_i;
  assign rise   = ~prev_q & lvl_i;
  assign active = evt_en_i & mon_en_i & settled_i;

  always_comb
    unique case (irq_edge_i)
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = fall;
    endcase

  assign irq_set = active & ~mode_rst_i & hit;
  assign fire_o  = active & mode_rst_i & fall & ~rst_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      irq_q  <= irq_set;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                det_q <= 1'b0;
    else if (irq_set || fire_o) det_q <= 1'b1;
    else if (det_clr_i)         det_q <= 1'b0;

  assign irq_o = irq_q;
  assign det_o = det_q;

  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_en_i && mon_en_i) |=> !irq_q);
  p_irq_reset_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_rst_i |=> !irq_q);
  p_settle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settled_i |=> !irq_q);
  p_det_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> det_q);
endmodule

// File: rtl/vm_reset_hold.sv
module vm_reset_hold #(
  parameter int unsigned HOLD = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic lvl_i,
  input  logic neg_type_i,
  output logic rst_o
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] cnt_q;
  logic          rst_q, counting, done;

  // type 1 counts unconditionally, type 0 only while recovered
  assign counting = neg_type_i | lvl_i;
  assign done     = counting && (cnt_q == CW'(HOLD - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rst_q <= 1'b0;
      cnt_q <= '0;
    end else if (!rst_q) begin
      if (fire_i) begin
        rst_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (done) begin
      rst_q <= 1'b0;
      cnt_q <= '0;
    end else if (counting) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end

  assign rst_o = rst_q;

  p_hold_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> ($past(cnt_q) == CW'(HOLD - 1)));
  p_rst_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(fire_i));
endmodule

// File: rtl/volt_mon_ctrl.sv
module volt_mon_ctrl
  import vm_pkg::*;
#(
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_HOLD    = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmp_raw_i,
  input  logic [LVL_W-1:0]     lvl_code_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 filt_dis_i,
  input  logic                 mode_rst_i,
  input  logic                 neg_type_i,
  input  logic [1:0]           irq_edge_i,
  input  logic                 cmp_en_i,
  input  logic                 evt_en_i,
  input  logic                 mon_en_i,
  input  logic                 det_clr_i,
  output logic [LVL_W-1:0]     ladder_sel_o,
  output logic                 irq_o,
  output logic                 rst_req_o,
  output logic                 det_o
);
  logic cmp_sync, cmp_gated, lvl, settled, fire, rst_busy;
  logic [LVL_W-1:0] ladder_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ladder_q <= '0;
    else         ladder_q <= lvl_code_i;
  assign ladder_sel_o = ladder_q;

  vm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_sync)
  );

  // disabled comparator reads as "above threshold"
  assign cmp_gated = cmp_en_i ? cmp_sync : 1'b1;

  vm_filter u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_i     (cmp_gated),
    .div_sel_i (div_sel_i),
    .filt_dis_i(filt_dis_i),
    .lvl_o     (lvl),
    .settled_o (settled)
  );

  vm_event u_event (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .settled_i (settled),
    .evt_en_i  (evt_en_i),
    .mon_en_i  (mon_en_i),
    .mode_rst_i(mode_rst_i),
    .irq_edge_i(irq_edge_e'(irq_edge_i)),
    .det_clr_i (det_clr_i),
    .rst_busy_i(rst_busy),
    .irq_o     (irq_o),
    .fire_o    (fire),
    .det_o     (det_o)
  );

  vm_reset_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .lvl_i     (lvl),
    .neg_type_i(neg_type_i),
    .rst_o     (rst_busy)
  );
  assign rst_req_o = rst_busy;

  p_no_rst_irq_mode_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_rst_i && !rst_busy) |=> !rst_busy);
endmodule

// File: tb/volt_mon_ctrl_tb.sv
module volt_mon_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b1;
  logic [3:0] lvl_code = '0;
  logic [1:0] div_sel = '0;
  logic       filt_dis = 1'b1;
  logic       mode_rst = 1'b0;
  logic       neg_type = 1'b0;
  logic [1:0] irq_edge = '0;
  logic       cmp_en = 1'b0;
  logic       evt_en = 1'b0;
  logic       mon_en = 1'b0;
  logic       det_clr = 1'b0;
  logic [3:0] ladder_sel;
  logic       irq, rst_req, det;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int rst_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  volt_mon_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(cmp_raw), .lvl_code_i(lvl_code),
    .div_sel_i(div_sel), .filt_dis_i(filt_dis), .mode_rst_i(mode_rst),
    .neg_type_i(neg_type), .irq_edge_i(irq_edge), .cmp_en_i(cmp_en),
    .evt_en_i(evt_en), .mon_en_i(mon_en), .det_clr_i(det_clr),
    .ladder_sel_o(ladder_sel), .irq_o(irq), .rst_req_o(rst_req), .det_o(det)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rst_req) rst_seen++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit qualifies(input logic [1:0] e, input bit from, input bit to);
    if (from == to) return 1'b0;
    case (e)
      2'b01:   return to;
      2'b10:   return 1'b1;
      default: return !to;
    endcase
  endfunction

  task automatic clear_det();
    det_clr = 1'b1;
    idle(1);
    det_clr = 1'b0;
    idle(1);
  endtask

  task automatic toggle_run(input logic [1:0] e, input int steps, input string tag);
    int exp_cnt = 0;
    irq_edge = e;
    idle(4);
    irq_cnt = 0;
    for (int k = 0; k < steps; k++) begin
      bit nxt = ~cmp_raw;
      if (qualifies(e, cmp_raw, nxt)) exp_cnt++;
      cmp_raw = nxt;
      idle(4 + ($urandom % 9));
    end
    idle(6);
    chk(irq_cnt == exp_cnt, tag, irq_cnt, exp_cnt);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    chk(!irq && !rst_req && !det && ladder_sel == 0, "R1 reset state",
        {ladder_sel, irq, rst_req, det}, 0);
    idle(30);

    lvl_code = 4'd5;
    idle(2);
    chk(ladder_sel == 4'd5, "R2 ladder code", ladder_sel, 5);

    cmp_en = 1'b1; evt_en = 1'b1; mon_en = 1'b1;
    rst_seen = 0;
    idle(5);
    // R3 directed: each encoding with a fall then a rise
    toggle_run(2'b00, 2, "R3 edge fall");
    toggle_run(2'b01, 2, "R3 edge rise");
    toggle_run(2'b10, 2, "R3 edge both");
    toggle_run(2'b11, 2, "R3 edge reserved");
    for (int r = 0; r < 6; r++) toggle_run(2'($urandom % 4), 10 + ($urandom % 8), "R3 random");
    if (cmp_raw == 1'b0) begin cmp_raw = 1'b1; idle(8); end

    // R8
    irq_edge = 2'b00;
    cmp_raw = 1'b0; idle(8);
    chk(det == 1'b1, "R8 det set", det, 1);
    clear_det();
    chk(det == 1'b0, "R8 det cleared", det, 0);
    cmp_raw = 1'b1; idle(8);

    // R7
    irq_cnt = 0;
    evt_en = 1'b0;
    cmp_raw = 1'b0; idle(8); cmp_raw = 1'b1; idle(8);
    chk(irq_cnt == 0 && det == 0, "R7 evt_en off", irq_cnt + det, 0);
    evt_en = 1'b1; mon_en = 1'b0;
    cmp_raw = 1'b0; idle(8); cmp_raw = 1'b1; idle(8);
    chk(irq_cnt == 0 && det == 0, "R7 mon_en off", irq_cnt + det, 0);
    mon_en = 1'b1;

    // R6
    cmp_en = 1'b0;
    cmp_raw = 1'b0; idle(10);
    chk(irq_cnt == 0 && det == 0, "R6 gated comparator", irq_cnt + det, 0);
    cmp_raw = 1'b1; idle(4);
    cmp_en = 1'b1; idle(8);

    // R4: filter n=8
    div_sel = 2'd3; filt_dis = 1'b0;
    idle(40);
    irq_cnt = 0;
    cmp_raw = 1'b0; idle(3); cmp_raw = 1'b1;
    idle(40);
    chk(irq_cnt == 0, "R4 glitch rejected", irq_cnt, 0);
    cmp_raw = 1'b0; idle(50);
    chk(irq_cnt == 1, "R4 sustained fall", irq_cnt, 1);
    cmp_raw = 1'b1; idle(50);
    clear_det();

    // R5: n=4, crossing inside the settle window
    filt_dis = 1'b1; div_sel = 2'd2;
    idle(10);
    irq_cnt = 0;
    filt_dis = 1'b0; cmp_raw = 1'b0;
    idle(40);
    chk(irq_cnt == 0 && det == 0, "R5 settle window", irq_cnt + det, 0);
    cmp_raw = 1'b1; idle(40);
    cmp_raw = 1'b0; idle(40);
    chk(irq_cnt == 1, "R5 after window", irq_cnt, 1);
    cmp_raw = 1'b1; idle(40);
    filt_dis = 1'b1; idle(4);
    clear_det();

    chk(rst_seen == 0, "R12 no reset in irq mode", rst_seen, 0);

    // R9 / R10
    mode_rst = 1'b1; neg_type = 1'b1;
    irq_cnt = 0;
    cmp_raw = 1'b0;
    n = 0;
    while (!rst_req && n < 20) begin idle(1); n++; end
    chk(rst_req == 1'b1, "R9 reset asserted", rst_req, 1);
    n = 0;
    while (rst_req && n < 1000) begin n++; idle(1); end
    chk(n == 256, "R10 fixed hold", n, 256);
    idle(50);
    chk(rst_req == 1'b0, "R10 stays released", rst_req, 0);
    chk(irq_cnt == 0, "R9 no irq in reset mode", irq_cnt, 0);
    chk(det == 1'b1, "R8 det in reset mode", det, 1);
    cmp_raw = 1'b1; idle(10);
    clear_det();

    // R11
    neg_type = 1'b0;
    cmp_raw = 1'b0;
    idle(300);
    chk(rst_req == 1'b1, "R11 held while low", rst_req, 1);
    cmp_raw = 1'b1; idle(100);
    cmp_raw = 1'b0; idle(5);
    cmp_raw = 1'b1;
    n = 0;
    while (rst_req && n < 1000) begin idle(1); n++; end
    chk(n >= 254 && n <= 262, "R11 release after recovery", n, 256);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule